// File: doc/BRIEF.md
# DMA Interrupt Control and Flag Register

This block holds the 32-bit interrupt control word of a multi-channel DMA controller together with the logic that turns channel completions into a system interrupt. Software writes the word to set per-channel enables, a master enable, a force/bus-error bit and six general bits. The same write acknowledges completed channels by writing ones over their flags.

Each of the seven transfer engines reports completion with a one-cycle pulse. The pulse latches a sticky flag for that channel only when the channel is enabled. A bus-error input forces the master condition. Bit 31 mirrors the master condition. A one-cycle request toward the system interrupt controller is raised only when bit 31 goes from clear to set. The request stays quiet while the condition persists, and it is re-armed once the condition drops.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After synchronous reset the read value is 0x0000_0000 and `irq_pulse` is low.
- R2: A write stores only bits 0–5, bit 15 and bits 16–23 from `wr_data`. Bits 6–14 always read 0. Written values of bits 24–31 never set anything.
- R3: A write with a 1 at bit 24+n clears channel flag n. A 0 at that position keeps the flag.
- R4: A pulse on `ch_done[n]` sets flag bit 24+n only if enable bit 16+n was set before that cycle. A set flag stays set until it is cleared by a write.
- R5: A pulse on `bus_err` sets bit 15. Bit 15 stays set until a write puts 0 there.
- R6: Bit 31 reads 1 exactly when (bit 23 is set and any of bits 24–30 is set) or bit 15 is set. It follows each update on the next read.
- R7: `irq_pulse` is high for one cycle, in the same cycle that bit 31 changes from 0 to 1. It is never high while bit 31 was already 1.
- R8: When the master condition stops holding, bit 31 clears. A later return of the condition raises a new `irq_pulse`.
- R9: If a completion pulse and a write-1-to-clear hit the same enabled channel in one cycle, the flag ends up set.
- R10: If `bus_err` and a write with bit 15 = 0 arrive in the same cycle, bit 15 ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write value |
| ch_done | input | 7 | Per-channel transfer-complete pulses |
| bus_err | input | 1 | Bus-error pulse; sets the force bit |
| rd_data | output | 32 | Current register value |
| irq_pulse | output | 1 | One-cycle request to the system interrupt controller |

## Verification
Several corner cases are targeted. A completion on a disabled channel must leave the flags untouched; a design that ignored the enable would raise flags on its own. The write-1-to-clear is driven in the same cycle as a completion and in the same cycle as a bus error. A design with the wrong priority would lose the event, and the interrupt would never be seen. The request is checked across a held condition, a dropped condition and a re-raised condition. A level-driven design would raise a stream of requests, and a design that never re-arms would stay silent after the first one.

// File: rtl/dicr_pkg.sv
package dicr_pkg;

    localparam int REG_W     = 32;
    localparam int CH_N      = 7;
    localparam int LOW_W     = 6;
    localparam int FORCE_BIT = 15;
    localparam int EN_LSB    = 16;
    localparam int MEN_BIT   = EN_LSB + CH_N;
    localparam int FLG_LSB   = MEN_BIT + 1;
    localparam int SENT_BIT  = FLG_LSB + CH_N;
    localparam int GAP_W     = FORCE_BIT - LOW_W;

    typedef struct packed {
        logic              master_en;
        logic [CH_N-1:0]   ch_en;
        logic              force_bit;
        logic [LOW_W-1:0]  misc;
    } ctrl_t;

    function automatic logic master_cond(input logic en,
                                         input logic [CH_N-1:0] flg,
                                         input logic frc);
        return (en && (|flg)) || frc;
    endfunction

    function automatic logic [REG_W-1:0] pack_read(input ctrl_t c,
                                                   input logic [CH_N-1:0] flg,
                                                   input logic sent);
        return {sent, flg, c.master_en, c.ch_en, c.force_bit,
                {GAP_W{1'b0}}, c.misc};
    endfunction

endpackage

// File: rtl/dicr_ctrl_reg.sv
module dicr_ctrl_reg
    import dicr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             bus_err,
    output ctrl_t            ctrl_q,
    output ctrl_t            ctrl_d
);

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en) begin
            ctrl_d.misc      = wr_data[LOW_W-1:0];
            ctrl_d.force_bit = wr_data[FORCE_BIT];
            ctrl_d.ch_en     = wr_data[EN_LSB +: CH_N];
            ctrl_d.master_en = wr_data[MEN_BIT];
        end
        // an error event outranks a write of 0 in the same cycle
        if (bus_err) begin
            ctrl_d.force_bit = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

endmodule

// File: rtl/dicr_flag_bank.sv
module dicr_flag_bank
    import dicr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [CH_N-1:0] clr_bits,
    input  logic [CH_N-1:0] ch_done,
    input  logic [CH_N-1:0] ch_en_q,
    output logic [CH_N-1:0] flags_q,
    output logic [CH_N-1:0] flags_d
);

    for (genvar i = 0; i < CH_N; i++) begin : g_cell
        logic set_i;
        logic clr_i;

        assign set_i      = ch_done[i] & ch_en_q[i];
        assign clr_i      = wr_en & clr_bits[i];
        // set has priority over clear so that no completion is lost
        assign flags_d[i] = set_i | (flags_q[i] & ~clr_i);

        always_ff @(posedge clk) begin
            if (rst) begin
                flags_q[i] <= 1'b0;
            end else begin
                flags_q[i] <= flags_d[i];
            end
        end
    end

endmodule

// File: rtl/dicr_irq_gen.sv
module dicr_irq_gen
    import dicr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            master_en_d,
    input  logic [CH_N-1:0] flags_d,
    input  logic            force_d,
    output logic            sent_q,
    output logic            irq_q
);

    logic sent_d;

    assign sent_d = master_cond(master_en_d, flags_d, force_d);

    always_ff @(posedge clk) begin
        if (rst) begin
            sent_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            sent_q <= sent_d;
            irq_q  <= sent_d & ~sent_q;
        end
    end

endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
    import dicr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic [CH_N-1:0]  ch_done,
    input  logic             bus_err,
    output logic [REG_W-1:0] rd_data,
    output logic             irq_pulse
);

    ctrl_t           ctrl_q;
    ctrl_t           ctrl_d;
    logic [CH_N-1:0] flags_q;
    logic [CH_N-1:0] flags_d;
    logic            sent_q;

    dicr_ctrl_reg i_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .bus_err (bus_err),
        .ctrl_q  (ctrl_q),
        .ctrl_d  (ctrl_d)
    );

    dicr_flag_bank i_flags (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .clr_bits (wr_data[FLG_LSB +: CH_N]),
        .ch_done  (ch_done),
        .ch_en_q  (ctrl_q.ch_en),
        .flags_q  (flags_q),
        .flags_d  (flags_d)
    );

    dicr_irq_gen i_irq (
        .clk         (clk),
        .rst         (rst),
        .master_en_d (ctrl_d.master_en),
        .flags_d     (flags_d),
        .force_d     (ctrl_d.force_bit),
        .sent_q      (sent_q),
        .irq_q       (irq_pulse)
    );

    assign rd_data = pack_read(ctrl_q, flags_q, sent_q);

endmodule

// File: rtl/dma_irq_ctrl_chk.sv
module dma_irq_ctrl_chk
    import dicr_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic [CH_N-1:0]  ch_done,
    input logic             bus_err,
    input logic [REG_W-1:0] rd_data,
    input logic             irq_pulse
);

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (rd_data == '0) && !irq_pulse);

    a_r2_gap_zero: assert property (@(posedge clk) disable iff (rst)
        rd_data[FORCE_BIT-1:LOW_W] == '0);

    a_r5_err_sets_force: assert property (@(posedge clk) disable iff (rst)
        bus_err |=> rd_data[FORCE_BIT]);

    a_r6_master_view: assert property (@(posedge clk) disable iff (rst)
        rd_data[SENT_BIT] == ((rd_data[MEN_BIT] && (|rd_data[FLG_LSB +: CH_N]))
                              || rd_data[FORCE_BIT]));

    a_r7_pulse_on_rise: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> rd_data[SENT_BIT] && !$past(rd_data[SENT_BIT]));

    a_r7_rise_has_pulse: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_data[SENT_BIT]) |-> irq_pulse);

    for (genvar n = 0; n < CH_N; n++) begin : g_ch
        // R4: a flag only appears after an enabled completion
        a_r4_flag_source: assert property (@(posedge clk) disable iff (rst)
            $rose(rd_data[FLG_LSB+n]) |-> $past(ch_done[n]) && $past(rd_data[EN_LSB+n]));

        // R9: an enabled completion always lands, even against a clear
        a_r9_done_wins: assert property (@(posedge clk) disable iff (rst)
            (ch_done[n] && rd_data[EN_LSB+n]) |=> rd_data[FLG_LSB+n]);
    end

endmodule

bind dma_irq_ctrl dma_irq_ctrl_chk i_dma_irq_ctrl_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .ch_done   (ch_done),
    .bus_err   (bus_err),
    .rd_data   (rd_data),
    .irq_pulse (irq_pulse)
);

// File: tb/test_dma_irq_ctrl.sv
module test_dma_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [6:0]  ch_done;
    logic        bus_err;
    logic [31:0] rd_data;
    logic        irq_pulse;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    dma_irq_ctrl i_dma_irq_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .ch_done   (ch_done),
        .bus_err   (bus_err),
        .rd_data   (rd_data),
        .irq_pulse (irq_pulse)
    );

    task automatic chk(input string req, input logic [31:0] exp_rd, input logic exp_irq);
        checks++;
        if (rd_data !== exp_rd || irq_pulse !== exp_irq) begin
            errors++;
            $display("FAIL %s: rd=%08h irq=%0b expected rd=%08h irq=%0b",
                     req, rd_data, irq_pulse, exp_rd, exp_irq);
        end
    endtask

    // drive one cycle of stimulus from a negedge, return at the next negedge
    task automatic step(input logic w, input logic [31:0] d,
                        input logic [6:0] done, input logic be);
        wr_en   = w;
        wr_data = d;
        ch_done = done;
        bus_err = be;
        @(posedge clk);
        #1;
        wr_en   = 1'b0;
        wr_data = '0;
        ch_done = '0;
        bus_err = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", 32'h0000_0000, 1'b0);
    endtask

    task automatic t_write_mask();
        step(1'b1, 32'h7F7F_FFFF, '0, 1'b0);
        chk("R2 masked write, R6 force, R7 pulse", 32'h807F_803F, 1'b1);
        step(1'b0, '0, '0, 1'b0);
        chk("R7 single-cycle pulse", 32'h807F_803F, 1'b0);
        step(1'b1, 32'h0000_0000, '0, 1'b0);
        chk("R8 condition drop clears bit31", 32'h0000_0000, 1'b0);
    endtask

    task automatic t_flags();
        step(1'b1, 32'h007F_0000, '0, 1'b0);
        chk("R2 enables", 32'h007F_0000, 1'b0);
        step(1'b0, '0, 7'h05, 1'b0);
        chk("R4 enabled set, R6 no master", 32'h057F_0000, 1'b0);
        step(1'b1, 32'h0000_0000, '0, 1'b0);
        chk("R3 zero keeps flags", 32'h0500_0000, 1'b0);
        step(1'b0, '0, 7'h02, 1'b0);
        chk("R4 disabled channel ignored", 32'h0500_0000, 1'b0);
        step(1'b1, 32'h0100_0000, '0, 1'b0);
        chk("R3 write one clears", 32'h0400_0000, 1'b0);
        step(1'b1, 32'h0080_0000, '0, 1'b0);
        chk("R6 master enable with flag, R7 pulse", 32'h8480_0000, 1'b1);
        step(1'b0, '0, '0, 1'b0);
        chk("R7 no pulse while held", 32'h8480_0000, 1'b0);
        step(1'b1, 32'h0480_0000, '0, 1'b0);
        chk("R8 clear drops bit31", 32'h0080_0000, 1'b0);
        step(1'b1, 32'h00C0_0000, '0, 1'b0);
        chk("R2 enable ch6", 32'h00C0_0000, 1'b0);
        step(1'b0, '0, 7'h40, 1'b0);
        chk("R8 re-armed pulse", 32'hC0C0_0000, 1'b1);
    endtask

    task automatic t_collide();
        step(1'b1, 32'h40C0_0000, 7'h40, 1'b0);
        chk("R9 set beats clear", 32'hC0C0_0000, 1'b0);
        step(1'b1, 32'h40C0_0000, '0, 1'b0);
        chk("R3 clear alone", 32'h00C0_0000, 1'b0);
    endtask

    task automatic t_buserr();
        do_reset();
        chk("R1 second reset", 32'h0000_0000, 1'b0);
        step(1'b0, '0, '0, 1'b1);
        chk("R5 bus error sets force", 32'h8000_8000, 1'b1);
        step(1'b1, 32'h0000_0000, '0, 1'b1);
        chk("R10 error beats write of zero", 32'h8000_8000, 1'b0);
        step(1'b1, 32'h0000_0000, '0, 1'b0);
        chk("R5 write zero clears force", 32'h0000_0000, 1'b0);
    endtask

    initial begin
        rst     = 1'b1;
        wr_en   = 1'b0;
        wr_data = '0;
        ch_done = '0;
        bus_err = 1'b0;
        t_reset();
        t_write_mask();
        t_flags();
        t_collide();
        t_buserr();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule